// File: doc/BRIEF.md
# Branch Target Address Generator

This block takes one control-transfer instruction at a time, together with the address of the instruction that follows it, the accumulator and a 16-bit data pointer, and works out whether the branch is taken and where it goes. It covers seven forms. Paged 11-bit jumps and calls take their upper address bits from the next-instruction address. Long jumps and calls carry a full 16-bit address. A short jump and a jump-on-zero-accumulator use a signed byte offset. An indirect jump adds the accumulator to the data pointer. For each instruction it also reports the byte length and the cycle count. Any other opcode goes through as a non-branch.

Requests enter on a valid/ready pair and results leave on another valid/ready pair, with one register stage between them. The upstream side sees `in_ready` high whenever the output register is empty or is being drained in the same cycle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented from the next cycle and stays unchanged until the consumer raises `out_ready`. Stack handling for calls, returns and instruction fetch belong to neighbouring blocks.

Top module: `brt_unit`

## Requirements
- R1: An opcode whose low five bits are 00001 is a paged jump. It is taken, its target is {next_pc[15:11], opcode[7:5], op1}, its length is 2 and its cycle count is 3.
- R2: An opcode whose low five bits are 10001 is a paged call. It is taken, its target follows the R1 rule, its length is 2 and its cycle count is 6.
- R3: Opcode 0x02 is a long jump. It is taken, its target is {op1, op2} (op1 is the high byte), its length is 3 and its cycle count is 4.
- R4: Opcode 0x12 is a long call. It is taken, its target follows the R3 rule, its length is 3 and its cycle count is 6.
- R5: Opcode 0x80 is a short jump. It is taken, its target is next_pc plus op1 sign-extended to 16 bits, modulo 2^16, its length is 2 and its cycle count is 3.
- R6: Opcode 0x73 is an indirect jump. It is taken, its target is dptr plus the zero-extended accumulator, modulo 2^16, its length is 1 and its cycle count is 2.
- R7: Opcode 0x60 is jump-on-zero. Its length is 2 and its cycle count is 3. When the accumulator is zero it is taken with the R5 target. Otherwise taken is 0 and the target equals next_pc.
- R8: For the seven forms above `out_branch` is 1. Every other opcode gives out_branch 0, out_taken 0, out_target equal to next_pc, out_len 0 and out_cycles 0.
- R9: in_ready equals (not out_valid) or out_ready. A request accepted at one edge is shown on the outputs after that edge. While out_valid is high and out_ready is low, out_valid and every result field hold.
- R10: While reset is asserted and just after it is released, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_opcode | input | 8 | Instruction opcode |
| in_op1 | input | 8 | First operand byte (low address byte, high long byte, or offset) |
| in_op2 | input | 8 | Second operand byte (low long byte) |
| in_next_pc | input | 16 | Address of the following instruction |
| in_acc | input | 8 | Accumulator value |
| in_dptr | input | 16 | Data pointer value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_branch | output | 1 | Opcode is one of the seven branch forms |
| out_taken | output | 1 | Control transfers to out_target |
| out_target | output | 16 | Destination address, or next_pc when not taken |
| out_len | output | 2 | Instruction length in bytes |
| out_cycles | output | 3 | Cycle count |

## Verification
The bench builds the block with its default data width of 8, which gives a 16-bit address. At that width every one of the 256 opcodes can be swept, so the overlapping paged encodings and every non-branch code are all reached. Page-edge next-pc values, offsets of 0x7F and 0x80 across both ends of the address space, and a data pointer of 0xFFFF then reach the wrap-around cases. A pseudo-random out_ready pattern holds results stalled for several cycles, which exercises back-pressure.

// File: rtl/brt_pkg.sv
package brt_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_ABS_JMP,
    K_ABS_CALL,
    K_LONG_JMP,
    K_LONG_CALL,
    K_SHORT,
    K_INDIR,
    K_JZ
  } brt_kind_e;

  localparam int LEN_W = 2;
  localparam int CYC_W = 3;

endpackage

// File: rtl/brt_decode.sv
module brt_decode
  import brt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opcode,
  output brt_kind_e         kind,
  output logic [LEN_W-1:0]  len,
  output logic [CYC_W-1:0]  cycles
);

  localparam int SEL_W  = 5;
  localparam int FORM_N = 7;
  localparam logic [SEL_W-1:0]  SEL_AJMP  = 5'b00001;
  localparam logic [SEL_W-1:0]  SEL_ACALL = 5'b10001;
  localparam logic [DATA_W-1:0] OP_LJMP   = DATA_W'(8'h02);
  localparam logic [DATA_W-1:0] OP_LCALL  = DATA_W'(8'h12);
  localparam logic [DATA_W-1:0] OP_SJMP   = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] OP_JIND   = DATA_W'(8'h73);
  localparam logic [DATA_W-1:0] OP_JZ     = DATA_W'(8'h60);

  logic [SEL_W-1:0]  sel;
  logic [FORM_N-1:0] hit;

  assign sel    = opcode[SEL_W-1:0];
  assign hit[0] = (sel == SEL_AJMP);
  assign hit[1] = (sel == SEL_ACALL);
  assign hit[2] = (opcode == OP_LJMP);
  assign hit[3] = (opcode == OP_LCALL);
  assign hit[4] = (opcode == OP_SJMP);
  assign hit[5] = (opcode == OP_JIND);
  assign hit[6] = (opcode == OP_JZ);

  always_comb begin
    kind   = K_NONE;
    len    = '0;
    cycles = '0;
    if (hit[0]) begin
      kind = K_ABS_JMP;   len = LEN_W'(2); cycles = CYC_W'(3);
    end else if (hit[1]) begin
      kind = K_ABS_CALL;  len = LEN_W'(2); cycles = CYC_W'(6);
    end else if (hit[2]) begin
      kind = K_LONG_JMP;  len = LEN_W'(3); cycles = CYC_W'(4);
    end else if (hit[3]) begin
      kind = K_LONG_CALL; len = LEN_W'(3); cycles = CYC_W'(6);
    end else if (hit[4]) begin
      kind = K_SHORT;     len = LEN_W'(2); cycles = CYC_W'(3);
    end else if (hit[5]) begin
      kind = K_INDIR;     len = LEN_W'(1); cycles = CYC_W'(2);
    end else if (hit[6]) begin
      kind = K_JZ;        len = LEN_W'(2); cycles = CYC_W'(3);
    end
  end

  AST_SINGLE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R8

  AST_FORM_HAS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |-> (len != '0 && cycles >= CYC_W'(2))); // R8

endmodule

// File: rtl/brt_target.sv
module brt_target
  import brt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  brt_kind_e           kind,
  input  logic [DATA_W-1:0]   opcode,
  input  logic [DATA_W-1:0]   op1,
  input  logic [DATA_W-1:0]   op2,
  input  logic [2*DATA_W-1:0] next_pc,
  input  logic [DATA_W-1:0]   acc,
  input  logic [2*DATA_W-1:0] dptr,
  output logic                taken,
  output logic [2*DATA_W-1:0] target
);

  localparam int ADDR_W  = 2 * DATA_W;
  localparam int PAGE_LO = DATA_W + 3;

  logic [ADDR_W-1:0] paged_addr;
  logic [ADDR_W-1:0] long_addr;
  logic [ADDR_W-1:0] rel_addr;
  logic [ADDR_W-1:0] ind_addr;
  logic              acc_zero;

  assign paged_addr = {next_pc[ADDR_W-1:PAGE_LO], opcode[DATA_W-1:DATA_W-3], op1};
  assign long_addr  = {op1, op2};
  assign rel_addr   = next_pc + {{DATA_W{op1[DATA_W-1]}}, op1};
  assign ind_addr   = dptr + {{DATA_W{1'b0}}, acc};
  assign acc_zero   = (acc == '0);

  always_comb begin
    taken  = 1'b1;
    target = next_pc;
    case (kind)
      K_ABS_JMP, K_ABS_CALL:   target = paged_addr;
      K_LONG_JMP, K_LONG_CALL: target = long_addr;
      K_SHORT:                 target = rel_addr;
      K_INDIR:                 target = ind_addr;
      K_JZ: begin
        taken  = acc_zero;
        target = acc_zero ? rel_addr : next_pc;
      end
      default:                 taken = 1'b0;
    endcase
  end

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (target == next_pc)); // R8

  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_ABS_JMP || kind == K_ABS_CALL)
      |-> (target[ADDR_W-1:PAGE_LO] == next_pc[ADDR_W-1:PAGE_LO])); // R1

  AST_NONE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_NONE) |-> !taken); // R8

endmodule

// File: rtl/brt_out_stage.sv
module brt_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_valid && up_ready) begin
      full_q <= 1'b1;
      data_q <= up_data;
    end else if (dn_ready) begin
      full_q <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data))); // R9

  AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> dn_valid); // R9

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_valid |-> up_ready); // R9

endmodule

// File: rtl/brt_unit.sv
module brt_unit
  import brt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_opcode,
  input  logic [DATA_W-1:0]   in_op1,
  input  logic [DATA_W-1:0]   in_op2,
  input  logic [2*DATA_W-1:0] in_next_pc,
  input  logic [DATA_W-1:0]   in_acc,
  input  logic [2*DATA_W-1:0] in_dptr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_branch,
  output logic                out_taken,
  output logic [2*DATA_W-1:0] out_target,
  output logic [LEN_W-1:0]    out_len,
  output logic [CYC_W-1:0]    out_cycles
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int RES_W  = 2 + ADDR_W + LEN_W + CYC_W;

  brt_kind_e         kind;
  logic [LEN_W-1:0]  len_c;
  logic [CYC_W-1:0]  cyc_c;
  logic              taken_c;
  logic [ADDR_W-1:0] target_c;
  logic [RES_W-1:0]  res_c;
  logic [RES_W-1:0]  res_q;

  brt_decode #(.DATA_W(DATA_W)) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (in_opcode),
    .kind   (kind),
    .len    (len_c),
    .cycles (cyc_c)
  );

  brt_target #(.DATA_W(DATA_W)) u_target (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .opcode  (in_opcode),
    .op1     (in_op1),
    .op2     (in_op2),
    .next_pc (in_next_pc),
    .acc     (in_acc),
    .dptr    (in_dptr),
    .taken   (taken_c),
    .target  (target_c)
  );

  assign res_c = {(kind != K_NONE), taken_c, target_c, len_c, cyc_c};

  brt_out_stage #(.W(RES_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (res_c),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (res_q)
  );

  assign {out_branch, out_taken, out_target, out_len, out_cycles} = res_q;

  AST_NB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_branch) |-> (!out_taken && out_len == '0 && out_cycles == '0)); // R8

  AST_TAKEN_IS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_taken) |-> out_branch); // R7

endmodule

// File: tb/sim_brt_unit.sv
module sim_brt_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [7:0]  in_op1 = '0;
  logic [7:0]  in_op2 = '0;
  logic [15:0] in_next_pc = '0;
  logic [7:0]  in_acc = '0;
  logic [15:0] in_dptr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_branch;
  logic        out_taken;
  logic [15:0] out_target;
  logic [1:0]  out_len;
  logic [2:0]  out_cycles;

  int total = 0;
  int bad = 0;
  bit running = 1'b0;
  logic [22:0] q[$];
  string rq[$];

  always #5 clk = ~clk;

  brt_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_op1(in_op1), .in_op2(in_op2),
    .in_next_pc(in_next_pc), .in_acc(in_acc), .in_dptr(in_dptr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_branch(out_branch), .out_taken(out_taken), .out_target(out_target),
    .out_len(out_len), .out_cycles(out_cycles)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [7:0] op);
    if (op[4:0] == 5'b00001) return "R1";
    if (op[4:0] == 5'b10001) return "R2";
    if (op == 8'h02) return "R3";
    if (op == 8'h12) return "R4";
    if (op == 8'h80) return "R5";
    if (op == 8'h73) return "R6";
    if (op == 8'h60) return "R7";
    return "R8";
  endfunction

  // packs {branch, taken, target, len, cycles}
  function automatic logic [22:0] model(input logic [7:0] op, input logic [7:0] a1,
      input logic [7:0] a2, input logic [15:0] npc, input logic [7:0] acc, input logic [15:0] dp);
    logic [15:0] rel;
    rel = npc + {{8{a1[7]}}, a1};
    if (op[4:0] == 5'b00001) return {2'b11, npc[15:11], op[7:5], a1, 2'd2, 3'd3};
    if (op[4:0] == 5'b10001) return {2'b11, npc[15:11], op[7:5], a1, 2'd2, 3'd6};
    if (op == 8'h02) return {2'b11, a1, a2, 2'd3, 3'd4};
    if (op == 8'h12) return {2'b11, a1, a2, 2'd3, 3'd6};
    if (op == 8'h80) return {2'b11, rel, 2'd2, 3'd3};
    if (op == 8'h73) return {2'b11, dp + {8'h00, acc}, 2'd1, 3'd2};
    if (op == 8'h60) begin
      if (acc == 8'h00) return {2'b11, rel, 2'd2, 3'd3};
      return {2'b10, npc, 2'd2, 3'd3};
    end
    return {2'b00, npc, 2'd0, 3'd0};
  endfunction

  task automatic send(input logic [7:0] op, input logic [7:0] a1, input logic [7:0] a2,
      input logic [15:0] npc, input logic [7:0] acc, input logic [15:0] dp);
    bit done;
    done = 1'b0;
    @(negedge clk);
    #1;
    in_opcode = op; in_op1 = a1; in_op2 = a2;
    in_next_pc = npc; in_acc = acc; in_dptr = dp;
    in_valid = 1'b1;
    while (!done) begin
      #3;
      if (in_ready) begin
        q.push_back(model(op, a1, a2, npc, acc, dp));
        rq.push_back(req_of(op));
        done = 1'b1;
      end
      @(posedge clk);
      if (!done) begin
        @(negedge clk);
        #1;
      end
    end
    #1;
    in_valid = 1'b0;
  endtask

  // monitor: picks out_ready each negedge, then scores the transfer at the coming edge
  initial begin
    logic [7:0]  lfsr;
    logic [22:0] held;
    bit          was_held;
    lfsr = 8'hA5;
    was_held = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      if (running) begin
        if (was_held)
          check(out_valid && {out_branch, out_taken, out_target, out_len, out_cycles} == held,
                "R9 hold", {8'h0, out_valid, out_branch, out_taken, out_target, out_len, out_cycles},
                {9'h1, held});
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = lfsr[0] | lfsr[1];
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R9 unexpected result", 32'(out_target), 32'h0);
          end else begin
            logic [22:0] e;
            string r;
            e = q.pop_front();
            r = rq.pop_front();
            check({out_branch, out_taken, out_target, out_len, out_cycles} == e, r,
                  {9'h0, out_branch, out_taken, out_target, out_len, out_cycles}, {9'h0, e});
          end
        end
        was_held = out_valid && !out_ready;
        held = {out_branch, out_taken, out_target, out_len, out_cycles};
      end
    end
  end

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && in_ready, "R10 in reset", {30'h0, out_valid, in_ready}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(!out_valid && in_ready, "R10 after release", {30'h0, out_valid, in_ready}, 32'h1);
    running = 1'b1;

    // R1 paged jump, page bits from next_pc
    send(8'h01, 8'h56, 8'h00, 16'h1234, 8'h00, 16'h0000);
    send(8'hE1, 8'hAA, 8'h00, 16'hF7FE, 8'h11, 16'h0000);
    send(8'hA1, 8'hFF, 8'h00, 16'h0800, 8'h00, 16'h0000);
    // R2 paged call
    send(8'h11, 8'h00, 8'h00, 16'hFFFF, 8'h00, 16'h0000);
    send(8'hF1, 8'h3C, 8'h99, 16'h47FF, 8'h00, 16'h0000);
    // R3 long jump, R4 long call
    send(8'h02, 8'hBE, 8'hEF, 16'h0100, 8'h00, 16'h0000);
    send(8'h12, 8'h00, 8'h01, 16'hABCD, 8'h00, 16'h0000);
    // R5 short jump, both directions and both wraps
    send(8'h80, 8'h80, 8'h00, 16'h0005, 8'h00, 16'h0000);
    send(8'h80, 8'h7F, 8'h00, 16'hFFF0, 8'h00, 16'h0000);
    send(8'h80, 8'h00, 8'h00, 16'h2222, 8'h00, 16'h0000);
    send(8'h80, 8'hFE, 8'h00, 16'h1000, 8'h00, 16'h0000);
    // R6 indirect jump
    send(8'h73, 8'h00, 8'h00, 16'h0000, 8'h01, 16'hFFFF);
    send(8'h73, 8'h00, 8'h00, 16'h0000, 8'hFF, 16'h1000);
    // R7 jump-on-zero taken and not taken
    send(8'h60, 8'hF0, 8'h00, 16'h0004, 8'h00, 16'h0000);
    send(8'h60, 8'hF0, 8'h00, 16'h0004, 8'h05, 16'h0000);
    send(8'h60, 8'h10, 8'h00, 16'h8000, 8'h80, 16'h0000);
    // R8 and all forms: full opcode sweep, zero and nonzero accumulator
    for (int i = 0; i < 256; i++)
      send(8'(i), 8'h9C, 8'h47, 16'h6E32, 8'h00, 16'h3F00);
    for (int i = 0; i < 256; i++)
      send(8'(i), 8'h21, 8'hD8, 16'hB7FD, 8'h42, 16'hFFF0);

    for (int k = 0; k < 200 && q.size() != 0; k++) @(posedge clk);
    check(q.size() == 0, "R9 drained", 32'(q.size()), 32'h0);
    @(negedge clk);
    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule